// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block collects a set of hardware interrupt sources and decides whether one of them may interrupt the processor, and which one. Every source has a request latch and a programmable three-bit priority level. A request is eligible when the global maskable-interrupt enable is set and its level is strictly above the processor's current priority level. Among eligible requests the block picks the highest level, breaking ties toward the lowest source index, and presents that source and its level on registered outputs.

A separate exit threshold drives a wake-up output used while the processor sits in a stop or wait mode. A fast-select bit beside that threshold turns level 7 into a high-speed class. The CPU acknowledges a taken interrupt by source index, which clears that request. Software reaches the configuration through a small write port: it sets levels, the global enable, the exit threshold and the fast-select bit, and it may clear requests but never set them.

Top module: `irq_level_ctrl`

## Requirements
- R1: Each source owns a control word at write address equal to its index; data bits [2:0] hold its level as an unsigned code where 3'b000 is level 0 and 3'b111 is level 7.
- R2: A pending request is presented only when its level is strictly greater than `ipl_i`, so a source at level 0 is never presented.
- R3: Write address N, data bit 0, is the global enable; it resets to 0, and while it is 0 `irq_o` stays low.
- R4: A pulse on a source's `event_i` bit sets its request; `ack_i` with `ack_src_i` equal to that index clears it.
- R5: A write to a source's control word with data bit 3 equal to 0 clears its request; bit 3 equal to 1 leaves the request unchanged and never sets it.
- R6: Among eligible requests the highest level wins; on equal levels the lowest source index wins.
- R7: `irq_o`, `irq_src_o`, `irq_lvl_o`, `irq_fast_o`, `wake_o` and `cfg_err_o` are registered and follow the request and configuration state one clock later; an event arriving in the same cycle as an acknowledge or a software clear of the same source keeps the request set.
- R8: While `low_power_i` is 1, `wake_o` rises when any pending request (whatever the global enable) has a level strictly greater than the exit threshold, held at write address N+1, data bits [2:0].
- R9: Write address N+1, data bit 3, is fast-select; when 1 a presented level-7 request raises `irq_fast_o`, when 0 `irq_fast_o` stays low.
- R10: With fast-select on and more than one source programmed to level 7, `cfg_err_o` is raised and only the lowest-index level-7 source is marked fast.
- R11: The exit threshold and fast-select reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| event_i | input | N | One-cycle request pulses, one bit per source |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | clog2(N+2) | Write address: source words, then enable, then exit register |
| wr_data_i | input | 4 | Write data |
| ack_i | input | 1 | CPU acknowledge strobe |
| ack_src_i | input | clog2(N) | Index of the acknowledged source |
| ipl_i | input | 3 | Processor current priority level |
| low_power_i | input | 1 | Processor is in stop or wait mode |
| irq_o | output | 1 | An eligible request is presented |
| irq_src_o | output | clog2(N) | Index of the presented source |
| irq_lvl_o | output | 3 | Level of the presented source |
| irq_fast_o | output | 1 | Presented request takes the high-speed path |
| wake_o | output | 1 | Wake-up request for stop or wait mode |
| cfg_err_o | output | 1 | More than one level-7 source while fast-select is on |

## Verification
The hardest situation to reach is the collision of a new event with an acknowledge of the same source in one clock, because the CPU normally acknowledges only after seeing the request. The bench drives `ack_i` and the matching `event_i` bit in the same cycle, independent of the presented outputs, and then confirms the request is still shown. The duplicate level-7 case is reached by programming a second source to level 7 while a higher-index level-7 request is already pending, so the winner stays the same while its fast marking must drop.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    localparam int LVL_W = 3;
    localparam int DATA_W = 4;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_TOP = '1;

    // Exit register contents: threshold plus fast-select.
    typedef struct packed {
        logic fast_en;
        lvl_t thr;
    } exit_cfg_t;

    function automatic logic lvl_above(input lvl_t a, input lvl_t b);
        return a > b;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_lvl_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 4,
    parameter int IW = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output lvl_t [N-1:0]        lvl_o,
    output logic [N-1:0]        sw_clr_o,
    output logic                ie_o,
    output exit_cfg_t           exit_o
);

    localparam logic [AW-1:0] CTRL_A = AW'(N);
    localparam logic [AW-1:0] EXIT_A = AW'(N + 1);

    lvl_t [N-1:0] lvl_q;
    logic         ie_q;
    exit_cfg_t    exit_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lvl_q  <= '0;
            ie_q   <= 1'b0;
            exit_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i < CTRL_A) begin
                lvl_q[wr_addr_i[IW-1:0]] <= wr_data_i[LVL_W-1:0];
            end else if (wr_addr_i == CTRL_A) begin
                ie_q <= wr_data_i[0];
            end else if (wr_addr_i == EXIT_A) begin
                exit_q <= '{fast_en: wr_data_i[3], thr: wr_data_i[LVL_W-1:0]};
            end
        end
    end

    // A source word write with bit 3 low clears that request.
    for (genvar g = 0; g < N; g++) begin : g_clr
        assign sw_clr_o[g] = wr_en_i && (wr_addr_i == AW'(g)) && !wr_data_i[3];
    end

    assign lvl_o  = lvl_q;
    assign ie_o   = ie_q;
    assign exit_o = exit_q;

endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [N-1:0]  event_i,
    input  logic          ack_i,
    input  logic [IW-1:0] ack_src_i,
    input  logic [N-1:0]  sw_clr_i,
    output logic [N-1:0]  req_o
);

    logic [N-1:0] req_q;
    logic [N-1:0] ack_mask;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ack_mask[i] = ack_i && (ack_src_i == IW'(i));
        end
    end

    // New events take precedence over any clear in the same cycle.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q <= '0;
        end else begin
            req_q <= (req_q & ~ack_mask & ~sw_clr_i) | event_i;
        end
    end

    assign req_o = req_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_lvl_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    input  lvl_t [N-1:0]  lvl_i,
    input  lvl_t          ipl_i,
    input  logic          ie_i,
    input  exit_cfg_t     exit_i,
    input  logic          low_power_i,
    output logic          hit_o,
    output logic [IW-1:0] src_o,
    output lvl_t          lvl_o,
    output logic          fast_o,
    output logic          wake_o,
    output logic          cfg_err_o
);

    logic [N-1:0]  top7;
    logic [IW-1:0] first7;
    logic          wake_any;

    for (genvar g = 0; g < N; g++) begin : g_top
        assign top7[g] = (lvl_i[g] == LVL_TOP);
    end

    always_comb begin
        hit_o    = 1'b0;
        src_o    = '0;
        lvl_o    = '0;
        wake_any = 1'b0;
        first7   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (top7[i]) begin
                first7 = IW'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && ie_i && lvl_above(lvl_i[i], ipl_i) &&
                (!hit_o || lvl_above(lvl_i[i], lvl_o))) begin
                hit_o = 1'b1;
                src_o = IW'(i);
                lvl_o = lvl_i[i];
            end
            if (req_i[i] && lvl_above(lvl_i[i], exit_i.thr)) begin
                wake_any = 1'b1;
            end
        end
    end

    assign fast_o    = hit_o && exit_i.fast_en && (lvl_o == LVL_TOP) && (src_o == first7);
    assign wake_o    = low_power_i && wake_any;
    assign cfg_err_o = exit_i.fast_en && ((top7 & (top7 - 1'b1)) != '0);

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = $clog2(N + 2),
    parameter int IW = $clog2(N)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N-1:0]      event_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ack_i,
    input  logic [IW-1:0]     ack_src_i,
    input  logic [LVL_W-1:0]  ipl_i,
    input  logic              low_power_i,
    output logic              irq_o,
    output logic [IW-1:0]     irq_src_o,
    output logic [LVL_W-1:0]  irq_lvl_o,
    output logic              irq_fast_o,
    output logic              wake_o,
    output logic              cfg_err_o
);

    typedef struct packed {
        logic          hit;
        logic [IW-1:0] src;
        lvl_t          lvl;
        logic          fast;
        logic          wake;
        logic          cfg_err;
    } verdict_t;

    lvl_t [N-1:0] lvl_q;
    logic [N-1:0] sw_clr;
    logic [N-1:0] req_q;
    logic         ie_q;
    exit_cfg_t    exit_cfg;
    verdict_t     nxt, out_q;

    irq_cfg_regs #(.N(N), .AW(AW), .IW(IW)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .lvl_o     (lvl_q),
        .sw_clr_o  (sw_clr),
        .ie_o      (ie_q),
        .exit_o    (exit_cfg)
    );

    irq_req_bank #(.N(N), .IW(IW)) u_req (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .event_i   (event_i),
        .ack_i     (ack_i),
        .ack_src_i (ack_src_i),
        .sw_clr_i  (sw_clr),
        .req_o     (req_q)
    );

    irq_arbiter #(.N(N), .IW(IW)) u_arb (
        .req_i       (req_q),
        .lvl_i       (lvl_q),
        .ipl_i       (ipl_i),
        .ie_i        (ie_q),
        .exit_i      (exit_cfg),
        .low_power_i (low_power_i),
        .hit_o       (nxt.hit),
        .src_o       (nxt.src),
        .lvl_o       (nxt.lvl),
        .fast_o      (nxt.fast),
        .wake_o      (nxt.wake),
        .cfg_err_o   (nxt.cfg_err)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    assign irq_o      = out_q.hit;
    assign irq_src_o  = out_q.src;
    assign irq_lvl_o  = out_q.lvl;
    assign irq_fast_o = out_q.fast;
    assign wake_o     = out_q.wake;
    assign cfg_err_o  = out_q.cfg_err;

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    ipl,
    input logic          low_power,
    input logic          ie,
    input logic          fast_en,
    input logic [N-1:0]  req_vec,
    input logic          irq,
    input logic [IW-1:0] irq_src,
    input logic [2:0]    irq_lvl,
    input logic          irq_fast,
    input logic          wake,
    input logic          cfg_err
);

    logic [N-1:0] req_d;

    always_ff @(posedge clk) begin
        if (rst) req_d <= '0;
        else     req_d <= req_vec;
    end

    // R2
    above_ipl_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_lvl > $past(ipl)));

    // R3
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ie) |-> !irq);

    // R6
    winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> req_d[irq_src]);

    // R9
    fast_class_chk: assert property (@(posedge clk) disable iff (rst)
        irq_fast |-> (irq && irq_lvl == 3'd7 && $past(fast_en)));

    // R8
    wake_mode_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(low_power));

    // R10
    cfg_err_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(fast_en));

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .ipl       (ipl_i),
    .low_power (low_power_i),
    .ie        (ie_q),
    .fast_en   (exit_cfg.fast_en),
    .req_vec   (req_q),
    .irq       (irq_o),
    .irq_src   (irq_src_o),
    .irq_lvl   (irq_lvl_o),
    .irq_fast  (irq_fast_o),
    .wake      (wake_o),
    .cfg_err   (cfg_err_o)
);

// File: tb/irq_level_ctrl_test.sv
`timescale 1ns/1ps
module irq_level_ctrl_test;

    localparam int N  = 8;
    localparam int AW = $clog2(N + 2);
    localparam int IW = $clog2(N);
    localparam logic [AW-1:0] A_EN   = AW'(N);
    localparam logic [AW-1:0] A_EXIT = AW'(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  event_i = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [3:0]    wr_data = '0;
    logic          ack = 1'b0;
    logic [IW-1:0] ack_src = '0;
    logic [2:0]    ipl = '0;
    logic          low_power = 1'b0;
    logic          irq, irq_fast, wake, cfg_err;
    logic [IW-1:0] irq_src;
    logic [2:0]    irq_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_level_ctrl #(.N(N)) uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .event_i     (event_i),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ack_i       (ack),
        .ack_src_i   (ack_src),
        .ipl_i       (ipl),
        .low_power_i (low_power),
        .irq_o       (irq),
        .irq_src_o   (irq_src),
        .irq_lvl_o   (irq_lvl),
        .irq_fast_o  (irq_fast),
        .wake_o      (wake),
        .cfg_err_o   (cfg_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; event_i = '0; wr_en = 1'b0; ack = 1'b0;
        ipl = '0; low_power = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        event_i = m;
        @(negedge clk);
        event_i = '0;
    endtask

    task automatic do_ack(input int s);
        ack = 1'b1; ack_src = IW'(s);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        chk("R3", "irq after reset", int'(irq), 0);
        chk("R11", "wake after reset", int'(wake), 0);
        chk("R10", "cfg_err after reset", int'(cfg_err), 0);
        wr(0, 4'b1101);
        pulse(8'h01);
        settle();
        chk("R3", "irq with enable off", int'(irq), 0);
        wr(A_EN, 4'b0001);
        settle();
        chk("R3", "irq after enable", int'(irq), 1);
        chk("R3", "src after enable", int'(irq_src), 0);
    endtask

    task automatic t_ipl();
        do_reset();
        wr(A_EN, 4'b0001);
        wr(2, 4'b1101);
        ipl = 3'd4;
        pulse(8'h04);
        chk("R7", "irq one cycle early", int'(irq), 0);
        settle();
        chk("R2", "irq lvl5 over ipl4", int'(irq), 1);
        chk("R2", "src", int'(irq_src), 2);
        chk("R1", "lvl", int'(irq_lvl), 5);
        ipl = 3'd5;
        settle();
        chk("R2", "irq at equal ipl", int'(irq), 0);
        do_ack(2);
        ipl = 3'd0;
        settle();
        chk("R4", "irq after ack", int'(irq), 0);
        wr(3, 4'b1000);
        pulse(8'h08);
        settle();
        chk("R2", "level 0 source", int'(irq), 0);
    endtask

    task automatic t_prio();
        do_reset();
        wr(A_EN, 4'b0001);
        wr(1, 4'b1011);
        wr(4, 4'b1110);
        wr(6, 4'b1110);
        pulse(8'b0101_0010);
        settle();
        chk("R6", "highest, lowest index", int'(irq_src), 4);
        chk("R6", "winner lvl", int'(irq_lvl), 6);
        do_ack(4);
        settle();
        chk("R4", "next tie member", int'(irq_src), 6);
        do_ack(6);
        settle();
        chk("R6", "last src", int'(irq_src), 1);
        chk("R1", "level code 3", int'(irq_lvl), 3);
    endtask

    task automatic t_swclr();
        do_reset();
        wr(A_EN, 4'b0001);
        wr(5, 4'b1100);
        pulse(8'h20);
        settle();
        chk("R4", "event sets", int'(irq), 1);
        wr(5, 4'b1100);
        settle();
        chk("R5", "write 1 keeps", int'(irq), 1);
        wr(5, 4'b0100);
        settle();
        chk("R5", "write 0 clears", int'(irq), 0);
        wr(5, 4'b1100);
        settle();
        chk("R5", "write 1 cannot set", int'(irq), 0);
    endtask

    task automatic t_race();
        do_reset();
        wr(A_EN, 4'b0001);
        wr(3, 4'b1010);
        pulse(8'h08);
        settle();
        chk("R4", "pending before race", int'(irq), 1);
        ack = 1'b1; ack_src = IW'(3); event_i = 8'h08;
        @(negedge clk);
        ack = 1'b0; event_i = '0;
        settle();
        chk("R7", "event with ack kept", int'(irq), 1);
        chk("R7", "src kept", int'(irq_src), 3);
        wr(3, 4'b0010);
        settle();
        chk("R5", "cleared", int'(irq), 0);
    endtask

    task automatic t_wake();
        do_reset();
        low_power = 1'b1;
        wr(0, 4'b1001);
        pulse(8'h01);
        settle();
        chk("R11", "thr reset 0 wakes", int'(wake), 1);
        chk("R3", "no irq, enable off", int'(irq), 0);
        wr(A_EXIT, 4'b0100);
        settle();
        chk("R8", "lvl1 below thr4", int'(wake), 0);
        wr(1, 4'b1100);
        pulse(8'h02);
        settle();
        chk("R8", "lvl4 equal thr4", int'(wake), 0);
        wr(2, 4'b1101);
        pulse(8'h04);
        settle();
        chk("R8", "lvl5 over thr4", int'(wake), 1);
        low_power = 1'b0;
        settle();
        chk("R8", "not low power", int'(wake), 0);
    endtask

    task automatic t_fast();
        do_reset();
        wr(A_EN, 4'b0001);
        wr(A_EXIT, 4'b1000);
        wr(5, 4'b1111);
        pulse(8'h20);
        settle();
        chk("R9", "lvl7 fast", int'(irq_fast), 1);
        chk("R9", "lvl7 src", int'(irq_src), 5);
        chk("R10", "single lvl7 no err", int'(cfg_err), 0);
        wr(A_EXIT, 4'b0000);
        settle();
        chk("R9", "fast-select off", int'(irq_fast), 0);
        chk("R9", "still presented", int'(irq), 1);
        wr(A_EXIT, 4'b1000);
        wr(2, 4'b1111);
        settle();
        chk("R10", "two lvl7 error", int'(cfg_err), 1);
        chk("R10", "higher index not fast", int'(irq_fast), 0);
        pulse(8'h04);
        settle();
        chk("R10", "lowest lvl7 wins", int'(irq_src), 2);
        chk("R10", "lowest lvl7 fast", int'(irq_fast), 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_ipl();
        t_prio();
        t_swclr();
        t_race();
        t_wake();
        t_fast();
        summary();
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

endmodule